// File: doc/BRIEF.md
# Loop Repeat-Buffer Bus Scheduler

This block schedules memory-bus traffic for a DSP core with separate program and data buses while the core runs one two-operand instruction over and over in a hardware loop. A start pulse loads the following values:

- a repeat count,
- the instruction address,
- a base and a stride for each of the two operand streams.

The scheduler then drives a program-bus port and a data-bus port. Each port has a request, an address and a read-data return. Memory is assumed to return read data in the same cycle as the request. The scheduler captures that data at the clock edge that ends the request cycle.

On the first pass the program bus spends one cycle fetching the instruction word into a one-entry repeat buffer. Both operands follow in the next cycle. On every later pass no fetch is made, because the buffered word is replayed. Operand 0 travels on the program bus and operand 1 on the data bus, in the same cycle. The operand addresses for pass k are base + k × stride, modulo 2^ADDR_W.

The controller has three states:

- `ST_IDLE`: no loop is running.
- `ST_FETCH`: the instruction fetch of the first pass.
- `ST_OPER`: one operand cycle per pass.

It has four transitions:

- `ST_IDLE`→`ST_FETCH` on an accepted start.
- `ST_FETCH`→`ST_OPER` unconditionally.
- `ST_OPER`→`ST_OPER` while passes remain.
- `ST_OPER`→`ST_IDLE` after the last pass.

Top module: `loop_bus_sched`

## Requirements
- R1: After reset, busy, both bus requests, op_valid, done and buf_valid are all low.
- R2: A start seen while idle causes, in the next cycle, a program-bus request at the latched instruction address with no data-bus request (fetch cycle).
- R3: The cycle after the fetch cycle carries both first-pass operands: program bus at operand-0 base, data bus at operand-1 base.
- R4: Every later pass takes exactly one cycle with no instruction fetch; pass k puts base0 + k·stride0 on the program bus and base1 + k·stride1 on the data bus.
- R5: op_valid is high in the cycle after each operand cycle. In that cycle op0_data equals the program-bus read data and op1_data equals the data-bus read data of that operand cycle, and op_insn equals the word read in the fetch cycle.
- R6: A repeat count N ≥ 1 gives exactly N passes; a count of 0 gives one pass.
- R7: done is a one-cycle pulse in the cycle after the last operand cycle, coinciding with the final op_valid, with busy already low.
- R8: buf_valid is high from the first operand cycle through the last operand cycle and low at all other times, including whenever no loop is running. op_insn holds steady while buf_valid stays high.
- R9: A start that arrives while busy is high is ignored: the running loop's addresses, pass count and instruction are unaffected.
- R10: busy is high from the fetch cycle through the last operand cycle, and neither bus is requested while busy is low.
- R11: Operand address arithmetic wraps modulo 2^ADDR_W, so negative strides are expressed in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loop start request, honoured only when idle |
| rep_count | input | CNT_W | Number of passes (0 means one) |
| insn_addr | input | ADDR_W | Program address of the looped instruction |
| op0_base | input | ADDR_W | First address of operand stream 0 |
| op0_stride | input | ADDR_W | Per-pass increment of operand stream 0 |
| op1_base | input | ADDR_W | First address of operand stream 1 |
| op1_stride | input | ADDR_W | Per-pass increment of operand stream 1 |
| pbus_req | output | 1 | Program-bus read request |
| pbus_addr | output | ADDR_W | Program-bus address |
| pbus_rdata | input | DATA_W | Program-bus read data (same cycle) |
| dbus_req | output | 1 | Data-bus read request |
| dbus_addr | output | ADDR_W | Data-bus address |
| dbus_rdata | input | DATA_W | Data-bus read data (same cycle) |
| op_valid | output | 1 | Operand pair and instruction word are valid |
| op_insn | output | DATA_W | Instruction word from the repeat buffer |
| op0_data | output | DATA_W | Captured operand 0 |
| op1_data | output | DATA_W | Captured operand 1 |
| done | output | 1 | One-cycle pulse at loop completion |
| busy | output | 1 | Loop in progress |
| buf_valid | output | 1 | Repeat buffer holds the loop's instruction |

## Verification
Two events can land in the same cycle.

- The delivery of the last operand pair coincides with the done pulse. The reference model expects op_valid, done and the last pass's data together in the cycle where busy has already dropped.
- A new start can arrive in that same cycle. The bench issues it exactly when done appears and expects an immediate fetch cycle on the next clock.

A start held high through a whole loop, including its last operand cycle, must produce nothing. This is checked by comparing every address and data value of that loop against the schedule of the first accepted start.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_OPER  = 2'd2
    } lrb_state_e;

    localparam int unsigned LRB_NUM_OPS = 2;

endpackage

// File: rtl/lrb_pass_ctr.sv
module lrb_pass_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    input  logic             step,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remaining_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining_q <= '0;
        end else if (load) begin
            remaining_q <= (count_in == '0) ? ONE : count_in;
        end else if (step && (remaining_q != '0)) begin
            remaining_q <= remaining_q - ONE;
        end
    end

    assign last = (remaining_q == ONE);

endmodule

// File: rtl/lrb_addr_gen.sv
module lrb_addr_gen #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr_q   <= base;
            stride_q <= stride;
        end else if (step) begin
            addr_q   <= addr_q + stride_q;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/lrb_insn_buf.sv
module lrb_insn_buf #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear,
    output logic [DATA_W-1:0] word,
    output logic              valid
);
    logic [DATA_W-1:0] word_q;
    logic              valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (capture) begin
                word_q  <= wdata;
                valid_q <= 1'b1;
            end else if (clear) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign word  = word_q;
    assign valid = valid_q;

endmodule

// File: rtl/loop_bus_sched.sv
module loop_bus_sched
    import lrb_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  rep_count,
    input  logic [ADDR_W-1:0] insn_addr,
    input  logic [ADDR_W-1:0] op0_base,
    input  logic [ADDR_W-1:0] op0_stride,
    input  logic [ADDR_W-1:0] op1_base,
    input  logic [ADDR_W-1:0] op1_stride,
    output logic              pbus_req,
    output logic [ADDR_W-1:0] pbus_addr,
    input  logic [DATA_W-1:0] pbus_rdata,
    output logic              dbus_req,
    output logic [ADDR_W-1:0] dbus_addr,
    input  logic [DATA_W-1:0] dbus_rdata,
    output logic              op_valid,
    output logic [DATA_W-1:0] op_insn,
    output logic [DATA_W-1:0] op0_data,
    output logic [DATA_W-1:0] op1_data,
    output logic              done,
    output logic              busy,
    output logic              buf_valid
);
    localparam int unsigned NUM_OPS = LRB_NUM_OPS;

    lrb_state_e state_q;
    lrb_state_e state_d;

    logic                          accept;
    logic                          fetch_cyc;
    logic                          op_cyc;
    logic                          last_pass;
    logic [ADDR_W-1:0]             insn_addr_q;
    logic [NUM_OPS-1:0][ADDR_W-1:0] op_base;
    logic [NUM_OPS-1:0][ADDR_W-1:0] op_stride;
    logic [NUM_OPS-1:0][ADDR_W-1:0] op_addr;

    logic              op_valid_q;
    logic              done_q;
    logic [DATA_W-1:0] op0_q;
    logic [DATA_W-1:0] op1_q;

    assign accept = start && (state_q == ST_IDLE);

    assign op_base[0]   = op0_base;
    assign op_base[1]   = op1_base;
    assign op_stride[0] = op0_stride;
    assign op_stride[1] = op1_stride;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and bus outputs
    always_comb begin
        state_d   = state_q;
        pbus_req  = 1'b0;
        pbus_addr = '0;
        dbus_req  = 1'b0;
        dbus_addr = '0;
        fetch_cyc = 1'b0;
        op_cyc    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                pbus_req  = 1'b1;
                pbus_addr = insn_addr_q;
                fetch_cyc = 1'b1;
                state_d   = ST_OPER;
            end
            ST_OPER: begin
                pbus_req  = 1'b1;
                pbus_addr = op_addr[0];
                dbus_req  = 1'b1;
                dbus_addr = op_addr[1];
                op_cyc    = 1'b1;
                if (last_pass) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_addr_q <= '0;
        end else if (accept) begin
            insn_addr_q <= insn_addr;
        end
    end

    lrb_pass_ctr #(
        .CNT_W (CNT_W)
    ) u_pass_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .count_in (rep_count),
        .step     (op_cyc),
        .last     (last_pass)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_agen
        lrb_addr_gen #(
            .ADDR_W (ADDR_W)
        ) u_agen (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (accept),
            .step   (op_cyc),
            .base   (op_base[g]),
            .stride (op_stride[g]),
            .addr   (op_addr[g])
        );
    end

    lrb_insn_buf #(
        .DATA_W (DATA_W)
    ) u_insn_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (fetch_cyc),
        .wdata   (pbus_rdata),
        .clear   (op_cyc && last_pass),
        .word    (op_insn),
        .valid   (buf_valid)
    );

    // Operand capture and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid_q <= 1'b0;
            done_q     <= 1'b0;
            op0_q      <= '0;
            op1_q      <= '0;
        end else begin
            op_valid_q <= op_cyc;
            done_q     <= op_cyc && last_pass;
            if (op_cyc) begin
                op0_q <= pbus_rdata;
                op1_q <= dbus_rdata;
            end
        end
    end

    assign op_valid = op_valid_q;
    assign done     = done_q;
    assign op0_data = op0_q;
    assign op1_data = op1_q;

endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              pbus_req,
    input logic              dbus_req,
    input logic              op_valid,
    input logic              done,
    input logic              buf_valid,
    input logic [DATA_W-1:0] op_insn
);
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pbus_req && !dbus_req)); // R10

    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (pbus_req && !dbus_req && !buf_valid)); // R2

    AST_FETCH_THEN_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_req && !dbus_req) |=> (pbus_req && dbus_req)); // R3

    AST_OPER_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_req |-> (buf_valid && pbus_req)); // R4

    AST_VALID_AFTER_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(dbus_req)); // R5

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (op_valid && !busy && !buf_valid)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_INSN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && $past(buf_valid)) |-> $stable(op_insn)); // R8

endmodule

bind loop_bus_sched lrb_checker #(
    .DATA_W (DATA_W)
) u_lrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pbus_req  (pbus_req),
    .dbus_req  (dbus_req),
    .op_valid  (op_valid),
    .done      (done),
    .buf_valid (buf_valid),
    .op_insn   (op_insn)
);

// File: tb/loop_bus_sched_tb.sv
`timescale 1ns/1ps
module loop_bus_sched_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] rep_count = '0;
    logic [AW-1:0] insn_addr = '0;
    logic [AW-1:0] op0_base = '0, op0_stride = '0, op1_base = '0, op1_stride = '0;
    logic          pbus_req, dbus_req, op_valid, done, busy, buf_valid;
    logic [AW-1:0] pbus_addr, dbus_addr;
    logic [DW-1:0] pbus_rdata, dbus_rdata, op_insn, op0_data, op1_data;

    int n_checks = 0;
    int n_fail   = 0;
    string ctx = "R1";

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] pmem(input logic [AW-1:0] a);
        return (a * 16'd3) ^ 16'h5A3C;
    endfunction

    function automatic logic [DW-1:0] dmem(input logic [AW-1:0] a);
        return {a[7:0], a[15:8]} + 16'h0101;
    endfunction

    assign pbus_rdata = pmem(pbus_addr);
    assign dbus_rdata = dmem(dbus_addr);

    loop_bus_sched #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rep_count(rep_count),
        .insn_addr(insn_addr), .op0_base(op0_base), .op0_stride(op0_stride),
        .op1_base(op1_base), .op1_stride(op1_stride),
        .pbus_req(pbus_req), .pbus_addr(pbus_addr), .pbus_rdata(pbus_rdata),
        .dbus_req(dbus_req), .dbus_addr(dbus_addr), .dbus_rdata(dbus_rdata),
        .op_valid(op_valid), .op_insn(op_insn), .op0_data(op0_data),
        .op1_data(op1_data), .done(done), .busy(busy), .buf_valid(buf_valid)
    );

    typedef struct {
        logic          busy;
        logic          preq;
        logic [AW-1:0] paddr;
        logic          dreq;
        logic [AW-1:0] daddr;
        logic          opv;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [DW-1:0] insn;
        logic          done;
        logic          bv;
    } cyc_t;

    cyc_t exp_q[$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual=%h expected=%h", req, ctx, what, act, exp);
        end
    endtask

    function automatic cyc_t idle_cyc();
        cyc_t c;
        c.busy = 0; c.preq = 0; c.paddr = '0; c.dreq = 0; c.daddr = '0;
        c.opv = 0; c.d0 = '0; c.d1 = '0; c.insn = '0; c.done = 0; c.bv = 0;
        return c;
    endfunction

    // Build the expected schedule of one accepted loop
    task automatic plan_loop();
        cyc_t c;
        int n;
        logic [AW-1:0] pa, da, lpa, lda;
        logic [DW-1:0] iw;
        n  = (rep_count == 0) ? 1 : int'(rep_count);
        iw = pmem(insn_addr);
        c = idle_cyc();
        c.busy = 1; c.preq = 1; c.paddr = insn_addr;
        exp_q.push_back(c);
        lpa = '0; lda = '0;
        for (int k = 0; k < n; k++) begin
            pa = op0_base + AW'(k) * op0_stride;
            da = op1_base + AW'(k) * op1_stride;
            c = idle_cyc();
            c.busy = 1; c.preq = 1; c.paddr = pa; c.dreq = 1; c.daddr = da; c.bv = 1;
            c.opv = (k > 0); c.d0 = pmem(lpa); c.d1 = dmem(lda); c.insn = iw;
            exp_q.push_back(c);
            lpa = pa; lda = da;
        end
        c = idle_cyc();
        c.opv = 1; c.d0 = pmem(lpa); c.d1 = dmem(lda); c.insn = iw; c.done = 1;
        exp_q.push_back(c);
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cyc_t e;
        if (rst_n) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_cyc();
            chk("R10", "busy", 32'(busy), 32'(e.busy));
            chk(e.dreq ? "R4" : "R2", "pbus_req", 32'(pbus_req), 32'(e.preq));
            if (e.preq) chk(e.dreq ? "R4" : "R2", "pbus_addr", 32'(pbus_addr), 32'(e.paddr));
            chk("R3", "dbus_req", 32'(dbus_req), 32'(e.dreq));
            if (e.dreq) chk("R4", "dbus_addr", 32'(dbus_addr), 32'(e.daddr));
            chk("R5", "op_valid", 32'(op_valid), 32'(e.opv));
            if (e.opv) begin
                chk("R5", "op0_data", 32'(op0_data), 32'(e.d0));
                chk("R5", "op1_data", 32'(op1_data), 32'(e.d1));
                chk("R5", "op_insn", 32'(op_insn), 32'(e.insn));
            end
            chk("R7", "done", 32'(done), 32'(e.done));
            chk("R8", "buf_valid", 32'(buf_valid), 32'(e.bv));
            if (start && !e.busy) plan_loop();
        end
    end

    // Run one loop; hold keeps start high with altered settings while busy
    task automatic run_loop(input int cnt, input logic [AW-1:0] ia,
                            input logic [AW-1:0] b0, input logic [AW-1:0] s0,
                            input logic [AW-1:0] b1, input logic [AW-1:0] s1,
                            input bit hold, output int passes);
        passes = 0;
        rep_count = CW'(cnt); insn_addr = ia;
        op0_base = b0; op0_stride = s0; op1_base = b1; op1_stride = s1;
        start = 1'b1;
        @(posedge clk); #1;
        if (hold) begin
            rep_count = 8'd9; insn_addr = ia + 16'h0100;
            op0_base = b0 ^ 16'h0F0F; op1_base = b1 ^ 16'hF0F0;
            op0_stride = s0 + 16'd5; op1_stride = s1 + 16'd7;
        end else begin
            start = 1'b0;
        end
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            if (op_valid) passes++;
            if (hold) start = busy;
            if (done) break;
        end
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int p;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "pbus_req", 32'(pbus_req), 32'd0);
        chk("R1", "dbus_req", 32'(dbus_req), 32'd0);
        chk("R1", "op_valid", 32'(op_valid), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "buf_valid", 32'(buf_valid), 32'd0);
        repeat (2) @(posedge clk);
        #1;

        ctx = "R3";
        run_loop(3, 16'h0040, 16'h0100, 16'd1, 16'h0800, 16'd2, 1'b0, p);
        chk("R6", "passes count=3", 32'(p), 32'd3);
        repeat (2) @(posedge clk); #1;

        ctx = "R6";
        run_loop(0, 16'h0011, 16'h0200, 16'd4, 16'h0300, 16'd4, 1'b0, p);
        chk("R6", "passes count=0", 32'(p), 32'd1);
        @(posedge clk); #1;
        run_loop(1, 16'h0012, 16'h0210, 16'd3, 16'h0310, 16'd9, 1'b0, p);
        chk("R6", "passes count=1", 32'(p), 32'd1);
        repeat (3) @(posedge clk); #1;

        ctx = "R9";
        run_loop(4, 16'h0020, 16'h1000, 16'd8, 16'h2000, 16'd16, 1'b1, p);
        chk("R9", "passes with held start", 32'(p), 32'd4);
        start = 1'b0;
        repeat (2) @(posedge clk); #1;

        ctx = "R11";
        run_loop(5, 16'hFFFF, 16'hFFFE, 16'd3, 16'h0002, 16'hFFFF, 1'b0, p);
        chk("R11", "passes wrap", 32'(p), 32'd5);
        repeat (2) @(posedge clk); #1;

        ctx = "R7";
        run_loop(2, 16'h0033, 16'h0400, 16'd2, 16'h0500, 16'd1, 1'b0, p);
        chk("R6", "passes count=2", 32'(p), 32'd2);
        run_loop(3, 16'h0034, 16'h0600, 16'd1, 16'h0700, 16'd3, 1'b0, p);
        chk("R7", "back-to-back passes", 32'(p), 32'd3);
        repeat (4) @(posedge clk); #1;
        chk("R10", "idle at end", 32'(busy), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule